// File: doc/BRIEF.md
# Microcoded Memory-Cycle Pattern Sequencer

This block produces the control waveforms of an external memory access from a short program held in a small writable store of control words. A requester loads the store through a write port, then issues a one-cycle start pulse with the index of the first word. The sequencer runs one word every four clock cycles. Each word sets the general-purpose strobe lines for the first half and the second half of its span, picks what drives the address bus, and tells the sequencer what to do next: repeat the word, open or close a counted loop, stop the pattern, or leave for an exception routine at a fixed index.

The burst flag, port size and loop count are sampled with the start pulse and stay fixed until the pattern ends. An error or soft-reset indication from outside can cut a pattern short, but only where a word allows it. When a word marked as final completes, the strobes return to their idle levels and a one-cycle done flag is raised.

Top module: `mcyc_seq`

## Requirements
- R1: After reset, and whenever no pattern runs, every strobe line sits at its idle level (parameter `STB_IDLE`, all ones by default), the address bus is zero and done is low.
- R2: A start pulse seen while idle begins the pattern at `start_idx_i` in the next cycle. Each word occupies four cycles (T1 to T4). Strobe line i shows word bit 2i during T1 and T2 and word bit 2i+1 during T3 and T4.
- R3: The repeat field (word bits [2N+1:2N], N = strobe count) runs the word once for 00, twice for 01, three times for 10 and four times for 11 before the next word.
- R4: Loop bit 2N+2: the first word with it set opens a loop, and the next such word closes it. The words from opener to closer run max(loop count, 1) times in total, using the loop count captured at start.
- R5: When exception-enable bit 2N+3 is set in the current word and an error or soft-reset has been seen during this word or any earlier word of the pattern, the cycle after T4 runs T1 of word `EXC_IDX`.
- R6: If the current word has exception-enable clear, the seen exception stays pending and the pattern carries on. A later word with the bit set then takes the branch.
- R7: Once in the exception routine, the sequencer runs words until one with the last bit set. New error or soft-reset pulses are ignored there.
- R8: Address-select field bits [2N+5:2N+4]: 00 drives the column address (the request address with its low `OFF_W` bits plus the burst offset), 10 drives the request address shifted right by `ROW_BASE + row_shift_i`, 11 drives `mar_i`, and 01 drives zero.
- R9: On a burst, next-address bit 2N+6 adds 1, 2, 4 or 8 (port size code 00, 01, 10, 11) to the burst offset at the end of T1. The offset wraps within `OFF_W` bits and is cleared at start.
- R10: With the burst flag low, the next-address bit has no effect on the address bus.
- R11: Last bit 2N+7 ends the pattern after the word's final T4. In the following cycle done is high for exactly one cycle and the strobes are idle.
- R12: At the end of T4 a taken exception wins over a pending repeat, over the last bit and over loop handling. A repeat in progress wins over the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| start_idx_i | input | IW | Index of the first word of the pattern |
| burst_i | input | 1 | Pattern serves a burst access |
| psize_i | input | 2 | Port size code: 00 8-bit, 01 16-bit, 10 32-bit, 11 64-bit |
| loop_cnt_i | input | LCW | Number of loop passes |
| err_i | input | 1 | External transfer error |
| srst_i | input | 1 | External soft reset |
| row_shift_i | input | 2 | Extra right shift for the row address |
| req_addr_i | input | AW | Address from the requester |
| mar_i | input | AW | Memory address register contents |
| wr_en_i | input | 1 | Write enable for the word store |
| wr_idx_i | input | IW | Word store write index |
| wr_data_i | input | 2*NSTB+8 | Control word to write |
| stb_o | output | NSTB | General-purpose strobe lines |
| addr_o | output | AW | Address bus |
| done_o | output | 1 | One-cycle pattern-complete flag |

## Verification
The hard case is an exception input that arrives in the very T4 cycle of a word that allows the branch. The sequencer must treat that as seen and branch at once, even though the word still has repetitions left or carries the last bit. The bench drives soft-reset in exactly that cycle, and drives an error during the final word of a pattern. It expects the next cycle to show the exception routine's first word and no done pulse. A second pulse inside the routine must leave the routine's waveform unchanged.

// File: rtl/mcyc_pkg.sv
// Shared types for the memory-cycle pattern sequencer.
// Assumes the control part of a word sits above the strobe bits.
package mcyc_pkg;

    // Address bus source selected by a word
    typedef enum logic [1:0] {
        ASEL_COL = 2'b00,
        ASEL_RSV = 2'b01,
        ASEL_ROW = 2'b10,
        ASEL_MAR = 2'b11
    } asel_e;

    // Sub-cycle phase within one word
    typedef enum logic [1:0] {
        PH_T1 = 2'd0,
        PH_T2 = 2'd1,
        PH_T3 = 2'd2,
        PH_T4 = 2'd3
    } phase_e;

    // Control field of a word, most significant member first
    typedef struct packed {
        logic       last;
        logic       nxt;
        asel_e      asel;
        logic       exen;
        logic       loop;
        logic [1:0] rpt;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/mcyc_ram.sv
// Control-word store: one synchronous write port and one combinational read port.
// Assumes DEPTH is a power of two and that the contents need no reset.
module mcyc_ram #(
    parameter int DEPTH = 32,
    parameter int WW    = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic [WW-1:0] wr_data_i,
    input  logic [IW-1:0] rd_idx_i,
    output logic [WW-1:0] rd_data_o
);

    logic [WW-1:0] mem [DEPTH];

    // Store a word on a write request
    always_ff @(posedge clk) begin
        if (wr_en_i) mem[wr_idx_i] <= wr_data_i;
    end

    assign rd_data_o = mem[rd_idx_i];

endmodule

// File: rtl/mcyc_ctrl.sv
// Sequencing core: phase counter, repeat counter, loop tracking, exception
// pending and branch, and pattern completion.
// Assumes the current word's control bits are valid for the whole word span.
module mcyc_ctrl
    import mcyc_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int LCW     = 4,
    parameter int EXC_IDX = 24,
    localparam int IW     = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [IW-1:0]  start_idx_i,
    input  logic [LCW-1:0] loop_cnt_i,
    input  logic           exc_i,
    input  logic [1:0]     rpt_i,
    input  logic           loop_i,
    input  logic           exen_i,
    input  logic           last_i,
    output logic           act_o,
    output phase_e         ph_o,
    output logic [IW-1:0]  idx_o,
    output logic           done_o
);

    localparam logic [IW-1:0] EXC_AT = IW'(EXC_IDX);

    logic           act_q, act_n;
    phase_e         ph_q, ph_n;
    logic [IW-1:0]  idx_q, idx_n;
    logic [1:0]     rep_q, rep_n;
    logic           lp_open_q, lp_open_n;
    logic [IW-1:0]  lp_start_q, lp_start_n;
    logic [LCW-1:0] lp_cnt_q, lp_cnt_n;
    logic [LCW-1:0] lc_q, lc_n;
    logic           pend_q, pend_n;
    logic           in_exc_q, in_exc_n;
    logic           done_q, done_n;

    logic word_end, seen, take_exc;

    assign word_end = act_q && (ph_q == PH_T4);
    assign seen     = pend_q || exc_i;
    assign take_exc = word_end && exen_i && !in_exc_q && seen;

    // Next-state decision for all sequencing registers
    always_comb begin
        act_n      = act_q;
        ph_n       = ph_q;
        idx_n      = idx_q;
        rep_n      = rep_q;
        lp_open_n  = lp_open_q;
        lp_start_n = lp_start_q;
        lp_cnt_n   = lp_cnt_q;
        lc_n       = lc_q;
        pend_n     = pend_q;
        in_exc_n   = in_exc_q;
        done_n     = 1'b0;
        if (!act_q) begin
            pend_n   = 1'b0;
            in_exc_n = 1'b0;
            if (start_i) begin
                act_n     = 1'b1;
                idx_n     = start_idx_i;
                ph_n      = PH_T1;
                rep_n     = 2'd0;
                lp_open_n = 1'b0;
                lc_n      = loop_cnt_i;
            end
        end else begin
            ph_n   = phase_e'(ph_q + 2'd1);
            pend_n = seen && !in_exc_q;
            if (word_end) begin
                rep_n = 2'd0;
                if (take_exc) begin
                    idx_n     = EXC_AT;
                    in_exc_n  = 1'b1;
                    pend_n    = 1'b0;
                    lp_open_n = 1'b0;
                end else if (rep_q != rpt_i) begin
                    rep_n = rep_q + 2'd1;
                end else if (last_i) begin
                    act_n  = 1'b0;
                    done_n = 1'b1;
                    pend_n = 1'b0;
                end else if (loop_i && !lp_open_q) begin
                    lp_open_n  = 1'b1;
                    lp_start_n = idx_q;
                    lp_cnt_n   = lc_q;
                    idx_n      = idx_q + 1'b1;
                end else if (loop_i && (idx_q != lp_start_q)) begin
                    if (lp_cnt_q > LCW'(1)) begin
                        idx_n    = lp_start_q;
                        lp_cnt_n = lp_cnt_q - 1'b1;
                    end else begin
                        lp_open_n = 1'b0;
                        idx_n     = idx_q + 1'b1;
                    end
                end else begin
                    idx_n = idx_q + 1'b1;
                end
            end
        end
    end

    // Register update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q      <= 1'b0;
            ph_q       <= PH_T1;
            idx_q      <= '0;
            rep_q      <= '0;
            lp_open_q  <= 1'b0;
            lp_start_q <= '0;
            lp_cnt_q   <= '0;
            lc_q       <= '0;
            pend_q     <= 1'b0;
            in_exc_q   <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            act_q      <= act_n;
            ph_q       <= ph_n;
            idx_q      <= idx_n;
            rep_q      <= rep_n;
            lp_open_q  <= lp_open_n;
            lp_start_q <= lp_start_n;
            lp_cnt_q   <= lp_cnt_n;
            lc_q       <= lc_n;
            pend_q     <= pend_n;
            in_exc_q   <= in_exc_n;
            done_q     <= done_n;
        end
    end

    assign act_o  = act_q;
    assign ph_o   = ph_q;
    assign idx_o  = idx_q;
    assign done_o = done_q;

endmodule

// File: rtl/mcyc_addr.sv
// Address source selection and burst offset stepping.
// Assumes OFF_W >= 4 so the largest step fits, and that load_i marks an accepted start.
module mcyc_addr
    import mcyc_pkg::*;
#(
    parameter int AW       = 32,
    parameter int OFF_W    = 5,
    parameter int ROW_BASE = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          burst_i,
    input  logic [1:0]    psize_i,
    input  logic          act_i,
    input  phase_e        ph_i,
    input  asel_e         asel_i,
    input  logic          nxt_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [1:0]    row_shift_i,
    input  logic [AW-1:0] mar_i,
    output logic [AW-1:0] addr_o
);

    logic             burst_q;
    logic [1:0]       psz_q;
    logic [OFF_W-1:0] off_q;
    logic [OFF_W-1:0] step;
    logic [OFF_W-1:0] col_low;

    assign step    = OFF_W'(1) << psz_q;
    assign col_low = req_addr_i[OFF_W-1:0] + off_q;

    // Capture burst context at start and step the offset at the end of T1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q <= 1'b0;
            psz_q   <= 2'd0;
            off_q   <= '0;
        end else if (load_i) begin
            burst_q <= burst_i;
            psz_q   <= psize_i;
            off_q   <= '0;
        end else if (act_i && ph_i == PH_T1 && nxt_i && burst_q) begin
            off_q <= off_q + step;
        end
    end

    // Drive the address bus from the selected source
    always_comb begin
        addr_o = '0;
        if (act_i) begin
            unique case (asel_i)
                ASEL_COL: addr_o = {req_addr_i[AW-1:OFF_W], col_low};
                ASEL_ROW: addr_o = req_addr_i >> (ROW_BASE + int'(row_shift_i));
                ASEL_MAR: addr_o = mar_i;
                default:  addr_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/mcyc_seq.sv
// Top of the memory-cycle pattern sequencer: word store, sequencing core,
// address path and per-line strobe phase selection.
// Assumes DEPTH is a power of two and EXC_IDX < DEPTH.
module mcyc_seq
    import mcyc_pkg::*;
#(
    parameter int               NSTB     = 4,
    parameter int               DEPTH    = 32,
    parameter int               AW       = 32,
    parameter int               OFF_W    = 5,
    parameter int               LCW      = 4,
    parameter int               ROW_BASE = 8,
    parameter int               EXC_IDX  = 24,
    parameter logic [NSTB-1:0]  STB_IDLE = '1,
    localparam int              IW       = $clog2(DEPTH),
    localparam int              WW       = 2 * NSTB + CTL_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [IW-1:0]  start_idx_i,
    input  logic           burst_i,
    input  logic [1:0]     psize_i,
    input  logic [LCW-1:0] loop_cnt_i,
    input  logic           err_i,
    input  logic           srst_i,
    input  logic [1:0]     row_shift_i,
    input  logic [AW-1:0]  req_addr_i,
    input  logic [AW-1:0]  mar_i,
    input  logic           wr_en_i,
    input  logic [IW-1:0]  wr_idx_i,
    input  logic [WW-1:0]  wr_data_i,
    output logic [NSTB-1:0] stb_o,
    output logic [AW-1:0]  addr_o,
    output logic           done_o
);

    logic [WW-1:0] word;
    ctl_t          ctl;
    logic          act;
    phase_e        ph;
    logic [IW-1:0] idx;
    logic          load;
    logic          first_half;

    assign ctl        = ctl_t'(word[WW-1:2*NSTB]);
    assign load       = start_i && !act;
    assign first_half = (ph == PH_T1) || (ph == PH_T2);

    mcyc_ram #(.DEPTH(DEPTH), .WW(WW)) u_ram (
        .clk       (clk),
        .wr_en_i   (wr_en_i),
        .wr_idx_i  (wr_idx_i),
        .wr_data_i (wr_data_i),
        .rd_idx_i  (idx),
        .rd_data_o (word)
    );

    mcyc_ctrl #(.DEPTH(DEPTH), .LCW(LCW), .EXC_IDX(EXC_IDX)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_idx_i (start_idx_i),
        .loop_cnt_i  (loop_cnt_i),
        .exc_i       (err_i | srst_i),
        .rpt_i       (ctl.rpt),
        .loop_i      (ctl.loop),
        .exen_i      (ctl.exen),
        .last_i      (ctl.last),
        .act_o       (act),
        .ph_o        (ph),
        .idx_o       (idx),
        .done_o      (done_o)
    );

    mcyc_addr #(.AW(AW), .OFF_W(OFF_W), .ROW_BASE(ROW_BASE)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .burst_i     (burst_i),
        .psize_i     (psize_i),
        .act_i       (act),
        .ph_i        (ph),
        .asel_i      (ctl.asel),
        .nxt_i       (ctl.nxt),
        .req_addr_i  (req_addr_i),
        .row_shift_i (row_shift_i),
        .mar_i       (mar_i),
        .addr_o      (addr_o)
    );

    // One phase selector per strobe line
    for (genvar g = 0; g < NSTB; g++) begin : g_stb
        assign stb_o[g] = !act       ? STB_IDLE[g] :
                          first_half ? word[2*g]   : word[2*g+1];
    end

endmodule

// File: rtl/mcyc_seq_chk.sv
// Property checker for mcyc_seq, attached by bind.
// Assumes the bound instance exposes its core and address-path state.
module mcyc_seq_chk
    import mcyc_pkg::*;
#(
    parameter int              NSTB     = 4,
    parameter int              DEPTH    = 32,
    parameter int              AW       = 32,
    parameter int              OFF_W    = 5,
    parameter int              EXC_IDX  = 24,
    parameter logic [NSTB-1:0] STB_IDLE = '1,
    localparam int             IW       = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             act,
    input phase_e           ph,
    input logic [IW-1:0]    idx,
    input ctl_t             ctl,
    input logic             in_exc,
    input logic             exc_now,
    input logic             burst_q,
    input logic [OFF_W-1:0] off_q,
    input logic             wr_en,
    input logic [NSTB-1:0]  stb,
    input logic [AW-1:0]    addr,
    input logic             done
);

    a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        act && $past(act) |-> ph == phase_e'($past(ph) + 2'd1));

    a_r2_word_span: assert property (@(posedge clk) disable iff (!rst_n)
        act && $past(act) && ph != PH_T1 |-> idx == $past(idx));

    a_r2_stb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        act && $past(act) && (ph == PH_T2 || ph == PH_T4) && !$past(wr_en) |-> $stable(stb));

    a_r5_branch: assert property (@(posedge clk) disable iff (!rst_n)
        act && ph == PH_T4 && ctl.exen && !in_exc && exc_now
        |=> act && idx == IW'(EXC_IDX) && ph == PH_T1 && !done);

    a_r7_stay_exc: assert property (@(posedge clk) disable iff (!rst_n)
        act && in_exc && !(ph == PH_T4 && ctl.last) |=> act && in_exc);

    a_r8_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        act && ctl.asel == ASEL_RSV |-> addr == '0);

    a_r1_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> addr == '0 && stb == STB_IDLE);

    a_r10_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        act && $past(act) && !burst_q |-> $stable(off_q));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !act && stb == STB_IDLE);

endmodule

bind mcyc_seq mcyc_seq_chk #(
    .NSTB(NSTB), .DEPTH(DEPTH), .AW(AW), .OFF_W(OFF_W),
    .EXC_IDX(EXC_IDX), .STB_IDLE(STB_IDLE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .ph      (ph),
    .idx     (idx),
    .ctl     (ctl),
    .in_exc  (u_ctrl.in_exc_q),
    .exc_now (err_i | srst_i),
    .burst_q (u_addr.burst_q),
    .off_q   (u_addr.off_q),
    .wr_en   (wr_en_i),
    .stb     (stb_o),
    .addr    (addr_o),
    .done    (done_o)
);

// File: tb/mcyc_seq_test.sv
// Self-checking bench: expands each pattern into a queue of expected
// per-cycle outputs and compares the design on every falling edge.
module mcyc_seq_test;

    localparam int          EXC   = 24;
    localparam logic [31:0] REQ   = 32'h1234_5677;
    localparam logic [31:0] MAR   = 32'hCAFE_0040;
    localparam int          RS    = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  start_idx_i = '0;
    logic        burst_i = 1'b0;
    logic [1:0]  psize_i = '0;
    logic [3:0]  loop_cnt_i = '0;
    logic        err_i = 1'b0;
    logic        srst_i = 1'b0;
    logic [1:0]  row_shift_i = 2'(RS);
    logic [31:0] req_addr_i = REQ;
    logic [31:0] mar_i = MAR;
    logic        wr_en_i = 1'b0;
    logic [4:0]  wr_idx_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [3:0]  stb_o;
    logic [31:0] addr_o;
    logic        done_o;

    typedef struct {
        logic [3:0]  stb;
        logic [31:0] addr;
        logic        done;
    } exp_t;

    exp_t        q[$];
    logic [15:0] mem_m [32];
    int          n_chk = 0;
    int          n_fail = 0;
    string       cur = "R1";

    always #2 clk = ~clk;

    mcyc_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_idx_i(start_idx_i),
        .burst_i(burst_i), .psize_i(psize_i), .loop_cnt_i(loop_cnt_i),
        .err_i(err_i), .srst_i(srst_i), .row_shift_i(row_shift_i),
        .req_addr_i(req_addr_i), .mar_i(mar_i), .wr_en_i(wr_en_i),
        .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .stb_o(stb_o), .addr_o(addr_o), .done_o(done_o)
    );

    function automatic logic [15:0] mkw(bit last, bit nxt, int asel, bit exen,
                                        bit loop, int rpt, logic [7:0] s);
        return {last, nxt, 2'(asel), exen, loop, 2'(rpt), s};
    endfunction

    // Fall to the next negative edge and compare against the expected queue
    task automatic tick();
        exp_t e;
        @(negedge clk);
        if (q.size() > 0) e = q.pop_front();
        else begin e.stb = 4'hF; e.addr = '0; e.done = 1'b0; end
        n_chk++;
        if (stb_o !== e.stb || addr_o !== e.addr || done_o !== e.done) begin
            n_fail++;
            $display("FAIL %s: stb=%h addr=%h done=%b, expected stb=%h addr=%h done=%b",
                     cur, stb_o, addr_o, done_o, e.stb, e.addr, e.done);
        end
    endtask

    task automatic wr(int i, logic [15:0] w);
        wr_en_i = 1'b1; wr_idx_i = 5'(i); wr_data_i = w; mem_m[i] = w;
        tick();
        wr_en_i = 1'b0;
    endtask

    // Walk the program and queue the expected outputs of every cycle
    task automatic build(int s, bit b, int ps, int lc, int e1, int e2);
        int idx = s; int ph = 0; int rep = 0; int lpst = 0; int lpc = 0;
        int off = 0; int t = 0;
        bit lpo = 0; bit pend = 0; bit inx = 0; bit seen;
        logic [15:0] w;
        exp_t it;
        forever begin
            w = mem_m[idx];
            for (int i = 0; i < 4; i++) it.stb[i] = (ph < 2) ? w[2*i] : w[2*i+1];
            case (int'(w[13:12]))
                0: it.addr = {REQ[31:5], 5'(int'(REQ[4:0]) + off)};
                2: it.addr = REQ >> (8 + RS);
                3: it.addr = MAR;
                default: it.addr = '0;
            endcase
            it.done = 1'b0;
            q.push_back(it);
            seen = pend || (t == e1) || (t == e2);
            if (ph == 0 && w[14] && b) off = (off + (1 << ps)) % 32;
            pend = seen && !inx;
            if (ph == 3) begin
                if (w[11] && !inx && seen) begin
                    idx = EXC; inx = 1; pend = 0; lpo = 0; rep = 0;
                end else if (rep != int'(w[9:8])) begin
                    rep++;
                end else begin
                    rep = 0;
                    if (w[15]) begin
                        it.stb = 4'hF; it.addr = '0; it.done = 1'b1;
                        q.push_back(it);
                        return;
                    end else if (w[10] && !lpo) begin
                        lpo = 1; lpst = idx; lpc = lc; idx = (idx + 1) % 32;
                    end else if (w[10] && idx != lpst) begin
                        if (lpc > 1) begin idx = lpst; lpc--; end
                        else begin lpo = 0; idx = (idx + 1) % 32; end
                    end else idx = (idx + 1) % 32;
                end
            end
            ph = (ph + 1) % 4;
            t++;
            if (t > 4000) return;
        end
    endtask

    // Start a pattern; e1 pulses err_i and e2 pulses srst_i in that cycle
    task automatic run(string tag, int s, bit b, int ps, int lc, int e1, int e2);
        int t = 0;
        cur = tag;
        start_i = 1'b1; start_idx_i = 5'(s); burst_i = b;
        psize_i = 2'(ps); loop_cnt_i = 4'(lc);
        build(s, b, ps, lc, e1, e2);
        tick();
        start_i = 1'b0;
        err_i = (t == e1); srst_i = (t == e2);
        while (q.size() > 0) begin
            tick();
            t++;
            err_i = (t == e1); srst_i = (t == e2);
        end
        err_i = 1'b0; srst_i = 1'b0;
        tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur = "R1 reset state";
        tick();
        // R2 R3 R8 R11: plain pattern with row, column, reserved and register sources
        wr(0,  mkw(0, 0, 2, 0, 0, 0, 8'b10_01_11_00));
        wr(1,  mkw(0, 0, 0, 0, 0, 2, 8'b01_10_00_11));
        wr(2,  mkw(0, 0, 1, 0, 0, 1, 8'b00_11_10_01));
        wr(3,  mkw(1, 0, 3, 0, 0, 0, 8'b11_11_01_01));
        // R4: loop opener, body, closer, last
        wr(4,  mkw(0, 0, 0, 0, 1, 0, 8'b00_00_00_01));
        wr(5,  mkw(0, 0, 2, 0, 0, 0, 8'b00_00_01_00));
        wr(6,  mkw(0, 0, 3, 0, 1, 1, 8'b00_01_00_00));
        wr(7,  mkw(1, 0, 0, 0, 0, 0, 8'b01_00_00_00));
        // R9 R10: burst words with next-address set
        wr(10, mkw(0, 1, 0, 0, 0, 3, 8'b10_10_10_10));
        wr(11, mkw(1, 1, 0, 0, 0, 0, 8'b01_01_01_01));
        // R5 R6 R7 R12: exception gating
        wr(14, mkw(0, 0, 0, 0, 0, 3, 8'b11_00_11_00));
        wr(15, mkw(0, 0, 2, 1, 0, 1, 8'b00_11_00_11));
        wr(16, mkw(1, 0, 3, 1, 0, 0, 8'b10_01_10_01));
        wr(24, mkw(0, 0, 2, 1, 0, 1, 8'b01_10_01_10));
        wr(25, mkw(1, 0, 3, 0, 0, 0, 8'b11_00_00_11));
        cur = "R1 idle after load";
        tick();

        run("R2 R3 R8 R11 plain pattern", 0, 0, 0, 0, -1, -1);
        run("R4 loop three passes", 4, 0, 0, 3, -1, -1);
        run("R4 loop count zero", 4, 0, 0, 0, -1, -1);
        run("R9 burst 64-bit step", 10, 1, 3, 0, -1, -1);
        run("R9 burst 8-bit step", 10, 1, 0, 0, -1, -1);
        run("R9 burst 32-bit step", 10, 1, 2, 0, -1, -1);
        run("R10 no burst", 10, 0, 3, 0, -1, -1);
        run("R6 deferred error", 14, 0, 0, 0, 2, -1);
        run("R5 R12 soft reset in T4", 14, 0, 0, 0, -1, 19);
        run("R12 R7 error on last word, second ignored", 14, 0, 0, 0, 25, 29);
        run("R11 no exception", 14, 0, 0, 0, -1, -1);
        // R1: exception pulse while idle must not affect the next pattern
        cur = "R1 idle exception";
        err_i = 1'b1; tick(); err_i = 1'b0; tick();
        run("R1 R6 after idle error", 14, 0, 0, 0, -1, -1);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule